// File: doc/BRIEF.md
# Direct-Mapped Cache with One-Store-Late Data Write

This block is the memory-stage front of a small direct-mapped data cache whose store hits take a single cycle. A store only performs its tag lookup in the cycle it is issued. When the lookup hits, the store's line address, word offset, write data and byte enables are held in a one-entry pending-write register. The pending data is written into the data array later, in the cycle when the next store performs its own tag lookup. The data array port is otherwise idle during a tag-only cycle. The write path therefore never needs a second cycle for a store.

Loads read the tag and data arrays in the same cycle. When a load targets the word held in the pending-write register, the held bytes are merged over the array word. Line refill is handled outside the block. An external stall input freezes the request path. A fill port installs a complete line and its tag in one cycle. Each accepted request gets a registered response on the following cycle, carrying a hit flag and, for loads, the read word.

Top module: `delayed_write_cache`

## Requirements
- R1: A byte address splits, from the least significant bit upward, into byte-in-word (2 bits), word-in-line (2 bits), line index (3 bits) and tag (5 bits). A request hits only when the indexed line is valid and its stored tag equals the request tag.
- R2: After reset every line is invalid. A load that misses returns rsp_hit = 0 and rsp_rdata = 0.
- R3: In a cycle with fill_valid high, fill_line (tag above index) selects and validates a line. Word w of the line is taken from fill_data bits [32w+31:32w]. No request is taken that cycle, and no response follows.
- R4: A request accepted at a clock edge produces rsp_valid for exactly the following cycle, with rsp_write echoing its kind. Without an accepted request, rsp_valid is low.
- R5: A store that hits is held as the pending write. A load of the same word that follows returns the new data.
- R6: A pending write is committed to the data array in the cycle when the next store does its tag lookup, whether that store hits or misses. Its data then remains readable after the pending register has moved on.
- R7: A store that misses allocates nothing and leaves the cache contents unchanged. It reports rsp_hit = 0 and still commits any pending write, so that no earlier store is lost.
- R8: The load bypass applies only when the full line address (tag and index) and the word offset both match the pending write. A different word of the same line, or a different tag at the same index, reads the array.
- R9: While stall_i is high and no fill is present, a request is ignored: there is no response, and neither the pending write nor the arrays change.
- R10: A fill commits any pending write in the same cycle and then replaces the whole selected line.
- R11: Byte enable bit i covers data bits [8i+7:8i]. A store writes only its enabled bytes, both in the bypass and in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| stall_i | input | 1 | External stall; request ignored while high |
| fill_valid | input | 1 | Install a line this cycle |
| fill_line | input | 8 | Line address (tag, index) of the fill |
| fill_data | input | 128 | Whole line, word 0 in the low bits |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_write | output | 1 | Response belongs to a store |
| rsp_hit | output | 1 | Request hit |
| rsp_rdata | output | 32 | Load data, zero on miss or store |

## Verification
The bench builds the block with its default parameters: 8 lines of 4 words of 4 bytes and a 12-bit address. With these values, two addresses 0x80 apart collide on one index with different tags, and four words per line give same-line, different-word neighbours for the bypass match. The bench checks each load against a flat write-through reference memory and a shadow tag table. Its sequences include back-to-back stores, loads issued immediately after a store, partial byte enables, store misses while a write is pending, and fills while a write is pending.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
    localparam int DWB_ADDR_W     = 12;
    localparam int DWB_LINES      = 8;
    localparam int DWB_WORDS      = 4;
    localparam int DWB_WORD_BYTES = 4;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_FILL  = 2'd3
    } op_e;
endpackage

// File: rtl/dwb_tag_array.sv
module dwb_tag_array #(
    parameter  int LINES = 8,
    parameter  int TAG_W = 5,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0] tag_mem [LINES];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_idx] <= wr_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];

    // R3: an installed line reads as valid afterwards
    assert_fill_sets_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/dwb_data_array.sv
module dwb_data_array #(
    parameter  int LINES      = 8,
    parameter  int WORDS      = 4,
    parameter  int WORD_BYTES = 4,
    localparam int IDX_W      = $clog2(LINES),
    localparam int WOFF_W     = $clog2(WORDS),
    localparam int WORD_W     = 8 * WORD_BYTES,
    localparam int LINE_W     = WORDS * WORD_W
) (
    input  logic                  clk,
    input  logic [IDX_W-1:0]      rd_idx,
    input  logic [WOFF_W-1:0]     rd_word,
    output logic [WORD_W-1:0]     rd_data,
    input  logic                  ww_en,
    input  logic [IDX_W-1:0]      ww_idx,
    input  logic [WOFF_W-1:0]     ww_word,
    input  logic [WORD_W-1:0]     ww_data,
    input  logic [WORD_BYTES-1:0] ww_be,
    input  logic                  lw_en,
    input  logic [IDX_W-1:0]      lw_idx,
    input  logic [LINE_W-1:0]     lw_data
);
    logic [WORD_W-1:0] mem [LINES][WORDS];

    // Word write first, whole-line write last: a fill wins on the same line.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LINES; l++) begin
            for (int w = 0; w < WORDS; w++) begin
                if (ww_en && ww_idx == IDX_W'(l) && ww_word == WOFF_W'(w)) begin
                    for (int b = 0; b < WORD_BYTES; b++) begin
                        if (ww_be[b]) mem[l][w][8*b +: 8] <= ww_data[8*b +: 8];
                    end
                end
                if (lw_en && lw_idx == IDX_W'(l))
                    mem[l][w] <= lw_data[w*WORD_W +: WORD_W];
            end
        end
    end

    assign rd_data = mem[rd_idx][rd_word];
endmodule

// File: rtl/dwb_byte_merge.sv
module dwb_byte_merge #(
    parameter  int WORD_BYTES = 4,
    localparam int WORD_W     = 8 * WORD_BYTES
) (
    input  logic [WORD_W-1:0]     base,
    input  logic [WORD_W-1:0]     over,
    input  logic [WORD_BYTES-1:0] sel,
    output logic [WORD_W-1:0]     merged
);
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
        assign merged[8*b +: 8] = sel[b] ? over[8*b +: 8] : base[8*b +: 8];
    end
endmodule

// File: rtl/delayed_write_cache.sv
module delayed_write_cache import dwb_pkg::*; #(
    parameter  int ADDR_W     = DWB_ADDR_W,
    parameter  int LINES      = DWB_LINES,
    parameter  int WORDS      = DWB_WORDS,
    parameter  int WORD_BYTES = DWB_WORD_BYTES,
    localparam int WORD_W     = 8 * WORD_BYTES,
    localparam int LINE_W     = WORDS * WORD_W,
    localparam int BOFF_W     = $clog2(WORD_BYTES),
    localparam int WOFF_W     = $clog2(WORDS),
    localparam int IDX_W      = $clog2(LINES),
    localparam int LADDR_W    = ADDR_W - WOFF_W - BOFF_W,
    localparam int TAG_W      = LADDR_W - IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WORD_W-1:0]     req_wdata,
    input  logic [WORD_BYTES-1:0] req_be,
    input  logic                  stall_i,
    input  logic                  fill_valid,
    input  logic [LADDR_W-1:0]    fill_line,
    input  logic [LINE_W-1:0]     fill_data,
    output logic                  rsp_valid,
    output logic                  rsp_write,
    output logic                  rsp_hit,
    output logic [WORD_W-1:0]     rsp_rdata
);
    typedef struct packed {
        logic                  valid;
        logic [LADDR_W-1:0]    line;
        logic [WOFF_W-1:0]     word;
        logic [WORD_W-1:0]     data;
        logic [WORD_BYTES-1:0] be;
    } pend_t;

    typedef struct packed {
        pend_t             pend;
        logic              rvalid;
        logic              rwrite;
        logic              rhit;
        logic [WORD_W-1:0] rdata;
    } state_t;

    state_t state_d, state_q;

    logic [LADDR_W-1:0] req_line;
    logic [IDX_W-1:0]   req_idx;
    logic [TAG_W-1:0]   req_tag;
    logic [WOFF_W-1:0]  req_word;
    logic [BOFF_W-1:0]  unused_byte_off;

    assign req_line        = req_addr[ADDR_W-1 -: LADDR_W];
    assign req_idx         = req_line[IDX_W-1:0];
    assign req_tag         = req_line[LADDR_W-1 -: TAG_W];
    assign req_word        = req_addr[BOFF_W +: WOFF_W];
    assign unused_byte_off = req_addr[BOFF_W-1:0];

    op_e  op;
    logic accept;
    logic tag_valid;
    logic [TAG_W-1:0] tag_rd;
    logic tag_hit;
    logic bypass;
    logic commit;
    logic [WORD_W-1:0] arr_word;
    logic [WORD_W-1:0] merged_word;

    assign accept = req_valid && !stall_i && !fill_valid;

    always_comb begin
        if (fill_valid)   op = OP_FILL;
        else if (!accept) op = OP_IDLE;
        else if (req_write) op = OP_STORE;
        else              op = OP_LOAD;
    end

    dwb_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_valid (tag_valid),
        .rd_tag   (tag_rd),
        .wr_en    (fill_valid),
        .wr_idx   (fill_line[IDX_W-1:0]),
        .wr_tag   (fill_line[LADDR_W-1 -: TAG_W])
    );

    dwb_data_array #(.LINES(LINES), .WORDS(WORDS), .WORD_BYTES(WORD_BYTES)) u_data (
        .clk     (clk),
        .rd_idx  (req_idx),
        .rd_word (req_word),
        .rd_data (arr_word),
        .ww_en   (commit),
        .ww_idx  (state_q.pend.line[IDX_W-1:0]),
        .ww_word (state_q.pend.word),
        .ww_data (state_q.pend.data),
        .ww_be   (state_q.pend.be),
        .lw_en   (fill_valid),
        .lw_idx  (fill_line[IDX_W-1:0]),
        .lw_data (fill_data)
    );

    dwb_byte_merge #(.WORD_BYTES(WORD_BYTES)) u_merge (
        .base   (arr_word),
        .over   (state_q.pend.data),
        .sel    (bypass ? state_q.pend.be : '0),
        .merged (merged_word)
    );

    always_comb begin
        tag_hit = tag_valid && (tag_rd == req_tag);
        bypass  = state_q.pend.valid && (state_q.pend.line == req_line)
                  && (state_q.pend.word == req_word);
        commit  = state_q.pend.valid && (op == OP_FILL || op == OP_STORE);

        state_d        = state_q;
        state_d.rvalid = (op == OP_LOAD) || (op == OP_STORE);
        state_d.rwrite = (op == OP_STORE);
        state_d.rhit   = state_d.rvalid && tag_hit;
        state_d.rdata  = (op == OP_LOAD && tag_hit) ? merged_word : '0;

        if (commit) state_d.pend.valid = 1'b0;
        if (op == OP_STORE && tag_hit) begin
            state_d.pend.valid = 1'b1;
            state_d.pend.line  = req_line;
            state_d.pend.word  = req_word;
            state_d.pend.data  = req_wdata;
            state_d.pend.be    = req_be;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid = state_q.rvalid;
    assign rsp_write = state_q.rwrite;
    assign rsp_hit   = state_q.rhit;
    assign rsp_rdata = state_q.rdata;

    // R4: one response per accepted request, on the next cycle only
    assert_accept_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    assert_idle_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);
    // R2: a missing load returns zero
    assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_write && !rsp_hit) |-> (rsp_rdata == '0));
    // R7: a missing store leaves nothing pending
    assert_store_miss_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_write && !rsp_hit) |-> !state_q.pend.valid);
    // R10: a fill always drains the pending write
    assert_fill_drains_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !state_q.pend.valid);
    // R9: a stalled request leaves the pending write alone
    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !fill_valid) |=> $stable(state_q.pend));
endmodule

// File: tb/delayed_write_cache_bench.sv
module delayed_write_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] LD = 2'd0, ST = 2'd1, FL = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic        hit;
    } vec_t;

    localparam int NVEC = 26;
    localparam vec_t VEC [NVEC] = '{
        '{LD, 12'h010, 32'h0,         4'h0, 1'b0},
        '{ST, 12'h014, 32'h1111_1111, 4'hF, 1'b0},
        '{FL, 12'h010, 32'h0,         4'h0, 1'b0},
        '{LD, 12'h014, 32'h0,         4'h0, 1'b1},
        '{ST, 12'h018, 32'h2222_2222, 4'hF, 1'b1},
        '{LD, 12'h018, 32'h0,         4'h0, 1'b1},
        '{LD, 12'h01C, 32'h0,         4'h0, 1'b1},
        '{ST, 12'h010, 32'h3333_3333, 4'h3, 1'b1},
        '{LD, 12'h018, 32'h0,         4'h0, 1'b1},
        '{LD, 12'h010, 32'h0,         4'h0, 1'b1},
        '{ST, 12'h090, 32'h4444_4444, 4'hF, 1'b0},
        '{LD, 12'h010, 32'h0,         4'h0, 1'b1},
        '{LD, 12'h090, 32'h0,         4'h0, 1'b0},
        '{ST, 12'h024, 32'h7777_7777, 4'hF, 1'b0},
        '{LD, 12'h024, 32'h0,         4'h0, 1'b0},
        '{ST, 12'h01C, 32'h5555_5555, 4'h8, 1'b1},
        '{ST, 12'h014, 32'h6666_6666, 4'h4, 1'b1},
        '{LD, 12'h01C, 32'h0,         4'h0, 1'b1},
        '{LD, 12'h014, 32'h0,         4'h0, 1'b1},
        '{FL, 12'h020, 32'h0,         4'h0, 1'b0},
        '{LD, 12'h014, 32'h0,         4'h0, 1'b1},
        '{LD, 12'h024, 32'h0,         4'h0, 1'b1},
        '{FL, 12'h090, 32'h0,         4'h0, 1'b0},
        '{LD, 12'h090, 32'h0,         4'h0, 1'b1},
        '{LD, 12'h010, 32'h0,         4'h0, 1'b0},
        '{LD, 12'h01C, 32'h0,         4'h0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_write, stall_i, fill_valid;
    logic [11:0]  req_addr;
    logic [31:0]  req_wdata;
    logic [3:0]   req_be;
    logic [7:0]   fill_line;
    logic [127:0] fill_data;
    logic         rsp_valid, rsp_write, rsp_hit;
    logic [31:0]  rsp_rdata;

    int  total = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    logic [31:0] refmem [1024];
    logic        mvalid [8];
    logic [4:0]  mtag   [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    delayed_write_cache u_delayed_write_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .stall_i(stall_i), .fill_valid(fill_valid), .fill_line(fill_line),
        .fill_data(fill_data), .rsp_valid(rsp_valid), .rsp_write(rsp_write),
        .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic string req_of(input int i);
        case (i)
            0, 24, 25:  return "R2";
            1, 10, 13, 14: return "R7";
            2, 3, 22, 23:  return "R3";
            4, 5:       return "R5";
            6, 12:      return "R8";
            8, 11:      return "R6";
            7, 9, 15, 16, 17: return "R11";
            19, 20, 21: return "R10";
            default:    return "R1";
        endcase
    endfunction

    function automatic logic model_hit(input logic [11:0] a);
        return mvalid[a[6:4]] && (mtag[a[6:4]] == a[11:7]);
    endfunction

    task automatic idle_inputs();
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        req_be = '0; stall_i = 1'b0; fill_valid = 1'b0; fill_line = '0; fill_data = '0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [11:0] a,
                          input logic [31:0] wd, input logic [3:0] be,
                          input logic exp_hit, input string rq);
        logic [31:0] exp_d;
        exp_d = (op == LD && model_hit(a)) ? refmem[a[11:2]] : 32'h0;
        if (op == FL) begin
            fill_valid = 1'b1;
            fill_line  = a[11:4];
            for (int w = 0; w < 4; w++) fill_data[32*w +: 32] = refmem[{a[11:4], w[1:0]}];
        end else begin
            req_valid = 1'b1; req_write = (op == ST); req_addr = a;
            req_wdata = wd; req_be = be;
        end
        @(negedge clk);
        idle_inputs();
        if (op == FL) begin
            chk(rq, "no response in fill cycle", {31'b0, rsp_valid}, 32'd0);
            mvalid[a[6:4]] = 1'b1;
            mtag[a[6:4]]   = a[11:7];
        end else begin
            chk("R4", "rsp_valid", {31'b0, rsp_valid}, 32'd1);
            chk("R4", "rsp_write", {31'b0, rsp_write}, {31'b0, op == ST});
            chk(rq, "rsp_hit (R1 rule)", {31'b0, rsp_hit}, {31'b0, exp_hit});
            if (op == LD) chk(rq, "rsp_rdata", rsp_rdata, exp_d);
            if (op == ST) begin
                for (int b = 0; b < 4; b++)
                    if (be[b]) refmem[a[11:2]][8*b +: 8] = wd[8*b +: 8];
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) refmem[i] = 32'hC0DE_0000 + i;
        for (int i = 0; i < 8; i++) begin mvalid[i] = 1'b0; mtag[i] = '0; end
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R4", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);

        for (int i = 0; i < NVEC; i++)
            run_op(VEC[i].op, VEC[i].addr, VEC[i].wdata, VEC[i].be, VEC[i].hit, req_of(i));

        // R9: stalled store to a present line is dropped
        stall_i = 1'b1; req_valid = 1'b1; req_write = 1'b1;
        req_addr = 12'h094; req_wdata = 32'hDEAD_BEEF; req_be = 4'hF;
        @(negedge clk);
        idle_inputs();
        chk("R9", "no response while stalled", {31'b0, rsp_valid}, 32'd0);
        run_op(LD, 12'h094, 32'h0, 4'h0, 1'b1, "R9");

        // R1: differing only in the top tag bit misses
        run_op(LD, 12'h890, 32'h0, 4'h0, 1'b0, "R1");

        // R4: idle cycle gives no response
        @(negedge clk);
        chk("R4", "idle rsp_valid", {31'b0, rsp_valid}, 32'd0);

        // R2: reset invalidates the present line
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) mvalid[i] = 1'b0;
        run_op(LD, 12'h090, 32'h0, 4'h0, 1'b0, "R2");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule